// File: doc/BRIEF.md
# Receive Interrupt Request Generator

This block turns receiver status into interrupt requests for a serial receiver. It raises an idle-line request when the line goes idle. That request fires once per idle period. After it is acknowledged, it stays quiet until a new character arrives, however long the line stays idle. It also raises a receive-data request while the receive buffer holds a character. That request comes on one of two mutually exclusive outputs: a normal request when the character has no error, and an exception request when any of its error flags is set.

All interface pins are plain level or strobe signals. No data stream passes through the block, so it has no valid/ready handshake and never applies back-pressure. The interrupt controller samples the request levels. It returns a one-cycle acknowledge only for the idle request. The receive requests follow the buffer-full flag and clear when software empties the buffer.

Top module: `rx_irq_logic`

## Requirements
- R1: While `rst_n` is low, all three requests are low. Reset leaves the idle request armed, so the first idle period after reset can raise `idle_irq`.
- R2: When the block is armed and both `idle_line` and `idle_irq_en` are high in a cycle, `idle_irq` is high in the next cycle.
- R3: If `idle_line` or `idle_irq_en` is low in a cycle, `idle_irq` is low in the next cycle.
- R4: A cycle with `idle_ack` high and `rx_char_stb` low makes `idle_irq` low in the next cycle and disarms the idle request.
- R5: Once disarmed, `idle_irq` stays low for any length of idle line until a character strobe arrives. This holds even if the line leaves idle and returns.
- R6: A cycle with `rx_char_stb` high re-arms the idle request. If the strobe and `idle_ack` arrive in the same cycle, the strobe wins.
- R7: When `rx_irq_en` and `rx_full` are both high and all bits of `rx_err` are clear, `rx_irq_ok` is high in the next cycle.
- R8: When `rx_irq_en` and `rx_full` are both high and any bit of `rx_err` is set, `rx_irq_exc` is high in the next cycle. The bit map is: bit 0 parity error, bit 1 framing error, bit 2 overrun.
- R9: If `rx_irq_en` or `rx_full` is low in a cycle, both receive requests are low in the next cycle.
- R10: `rx_irq_ok` and `rx_irq_exc` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_line | input | 1 | Live idle status of the receive line |
| rx_char_stb | input | 1 | One-cycle pulse for each received character |
| rx_full | input | 1 | Receive buffer holds a character |
| rx_err | input | ERR_W | Error flags of the held character (parity, framing, overrun) |
| idle_irq_en | input | 1 | Idle interrupt enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| idle_ack | input | 1 | Acknowledge of the idle request |
| idle_irq | output | 1 | Idle interrupt request |
| rx_irq_ok | output | 1 | Receive request for an error-free character |
| rx_irq_exc | output | 1 | Receive request for a character with an error |

## Verification
Every request is registered. Each output therefore reflects the inputs of the previous cycle: exactly one cycle of latency, with no path from input to output inside a cycle. The bench drives inputs on the falling edge and lets one rising edge pass. It samples on the following falling edge, so each check sees the result of its own stimulus. Arm state carries over from one vector to the next, so the vector order encodes the acknowledge and re-arm history. Directed runs then hold the line idle for many cycles and cover reset.

// File: rtl/rxi_pkg.sv
package rxi_pkg;
  // positions of the error flags in rx_err
  localparam int ERR_PAR = 0;
  localparam int ERR_FRM = 1;
  localparam int ERR_OVR = 2;
  localparam int ERR_MIN_W = 3;

  typedef enum logic [1:0] {
    RXK_NONE = 2'b00,
    RXK_OK   = 2'b01,
    RXK_EXC  = 2'b10
  } rx_kind_e;
endpackage

// File: rtl/rxi_idle_arm.sv
module rxi_idle_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_line,
  input  logic idle_irq_en,
  input  logic rx_char_stb,
  input  logic idle_ack,
  output logic idle_irq
);
  logic arm_q;
  logic arm_d;
  logic req_q;

  // a new character re-arms even when an acknowledge lands in the same cycle
  always_comb begin
    arm_d = arm_q;
    if (idle_ack)    arm_d = 1'b0;
    if (rx_char_stb) arm_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q <= 1'b1;
      req_q <= 1'b0;
    end else begin
      arm_q <= arm_d;
      req_q <= idle_line & idle_irq_en & arm_d;
    end
  end

  assign idle_irq = req_q;
endmodule

// File: rtl/rxi_rx_class.sv
module rxi_rx_class
  import rxi_pkg::*;
#(
  parameter int ERR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_full,
  input  logic             rx_irq_en,
  input  logic [ERR_W-1:0] rx_err,
  output logic             rx_irq_ok,
  output logic             rx_irq_exc
);
  rx_kind_e kind_d;
  rx_kind_e kind_q;
  logic     any_err;

  assign any_err = |rx_err;

  always_comb begin
    kind_d = RXK_NONE;
    if (rx_irq_en && rx_full) kind_d = any_err ? RXK_EXC : RXK_OK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) kind_q <= RXK_NONE;
    else        kind_q <= kind_d;
  end

  assign rx_irq_ok  = (kind_q == RXK_OK);
  assign rx_irq_exc = (kind_q == RXK_EXC);
endmodule

// File: rtl/rx_irq_logic.sv
module rx_irq_logic
  import rxi_pkg::*;
#(
  parameter int ERR_W = ERR_MIN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_line,
  input  logic             rx_char_stb,
  input  logic             rx_full,
  input  logic [ERR_W-1:0] rx_err,
  input  logic             idle_irq_en,
  input  logic             rx_irq_en,
  input  logic             idle_ack,
  output logic             idle_irq,
  output logic             rx_irq_ok,
  output logic             rx_irq_exc
);
  rxi_idle_arm u_idle (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_line   (idle_line),
    .idle_irq_en (idle_irq_en),
    .rx_char_stb (rx_char_stb),
    .idle_ack    (idle_ack),
    .idle_irq    (idle_irq)
  );

  rxi_rx_class #(.ERR_W(ERR_W)) u_class (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_full    (rx_full),
    .rx_irq_en  (rx_irq_en),
    .rx_err     (rx_err),
    .rx_irq_ok  (rx_irq_ok),
    .rx_irq_exc (rx_irq_exc)
  );
endmodule

// File: rtl/rx_irq_logic_chk.sv
module rx_irq_logic_chk #(
  parameter int ERR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idle_line,
  input logic             rx_char_stb,
  input logic             rx_full,
  input logic [ERR_W-1:0] rx_err,
  input logic             idle_irq_en,
  input logic             rx_irq_en,
  input logic             idle_ack,
  input logic             idle_irq,
  input logic             rx_irq_ok,
  input logic             rx_irq_exc
);
  // independent record of "acknowledged since the last character"
  logic blocked_q;
  always_ff @(posedge clk) begin
    if (!rst_n)           blocked_q <= 1'b0;
    else if (rx_char_stb) blocked_q <= 1'b0;
    else if (idle_ack)    blocked_q <= 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !idle_irq && !rx_irq_ok && !rx_irq_exc);
  // R3
  idle_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(idle_line && idle_irq_en) |=> !idle_irq);
  // R4
  ack_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ack && !rx_char_stb |=> !idle_irq);
  // R5
  once_per_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_q && !rx_char_stb |=> !idle_irq);
  // R7
  ok_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_en && rx_full && (rx_err == '0) |=> rx_irq_ok);
  // R8
  exc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_en && rx_full && (rx_err != '0) |=> rx_irq_exc);
  // R9
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_irq_en && rx_full) |=> !rx_irq_ok && !rx_irq_exc);
  // R10
  rx_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_irq_ok && rx_irq_exc));
endmodule

bind rx_irq_logic rx_irq_logic_chk #(.ERR_W(ERR_W)) u_chk (.*);

// File: tb/rx_irq_logic_bench.sv
module rx_irq_logic_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idle_line = 1'b0;
  logic       rx_char_stb = 1'b0;
  logic       rx_full = 1'b0;
  logic [2:0] rx_err = 3'b000;
  logic       idle_irq_en = 1'b0;
  logic       rx_irq_en = 1'b0;
  logic       idle_ack = 1'b0;
  logic       idle_irq, rx_irq_ok, rx_irq_exc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  rx_irq_logic u_rx_irq_logic (.*);

  // {idle, ien, stb, ack, rien, full, err[2:0], exp_idle, exp_ok, exp_exc}
  localparam int NV = 12;
  localparam logic [11:0] VEC [NV] = '{
    12'b0_1_0_0_1_1_000_0_1_0, // R7 normal request, armed but line busy
    12'b1_0_0_0_1_1_001_0_0_1, // R3 enable low; R8 parity
    12'b1_1_0_0_0_1_000_1_0_0, // R2 idle fires; R9 rx enable low
    12'b1_1_0_1_1_0_000_0_0_0, // R4 acknowledge; R9 buffer empty
    12'b1_1_0_0_1_1_010_0_0_1, // R5 no refire; R8 framing
    12'b1_1_0_0_1_1_100_0_0_1, // R5 still idle; R8 overrun
    12'b0_1_1_0_1_1_000_0_1_0, // R6 character re-arms, line busy
    12'b1_1_0_0_0_0_000_1_0_0, // R6 idle fires again
    12'b1_1_1_1_1_1_111_1_0_1, // R6 strobe beats ack; R10 all errors
    12'b1_1_0_1_0_0_000_0_0_0, // R4 ack alone
    12'b0_1_0_0_0_0_000_0_0_0, // R3 line busy
    12'b1_1_0_0_0_0_000_0_0_0  // R5 line back idle, no character
  };

  task automatic check(input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 outputs low during reset with every cause present
    @(negedge clk);
    idle_line = 1; idle_irq_en = 1; rx_irq_en = 1; rx_full = 1; rx_err = 3'b010;
    step();
    check("R1 idle_irq in reset", idle_irq, 1'b0);
    check("R1 rx_irq_ok in reset", rx_irq_ok, 1'b0);
    check("R1 rx_irq_exc in reset", rx_irq_exc, 1'b0);
    idle_line = 0; rx_full = 0; rx_err = 0;
    rst_n = 1;
    step();

    for (int i = 0; i < NV; i++) begin
      {idle_line, idle_irq_en, rx_char_stb, idle_ack, rx_irq_en, rx_full, rx_err} = VEC[i][11:3];
      step();
      check($sformatf("vec %0d idle path (R2,R3,R4,R5,R6)", i), idle_irq, VEC[i][2]);
      check($sformatf("vec %0d normal (R7,R9)", i), rx_irq_ok, VEC[i][1]);
      check($sformatf("vec %0d exception (R8,R9)", i), rx_irq_exc, VEC[i][0]);
      check($sformatf("vec %0d R10 exclusive", i), rx_irq_ok & rx_irq_exc, 1'b0);
    end
    rx_char_stb = 0; idle_ack = 0;

    // R5 long idle after acknowledge stays silent
    idle_line = 1; idle_irq_en = 1;
    for (int k = 0; k < 60; k++) begin
      step();
      check("R5 long idle", idle_irq, 1'b0);
    end
    // R6 a character during the idle re-arms
    rx_char_stb = 1;
    step();
    rx_char_stb = 0;
    check("R6 re-arm on strobe", idle_irq, 1'b1);
    idle_ack = 1;
    step();
    idle_ack = 0;
    check("R4 ack clears", idle_irq, 1'b0);

    // R1 reset re-arms a disarmed block
    rst_n = 0;
    step();
    check("R1 reset idle", idle_irq, 1'b0);
    rst_n = 1;
    step();
    check("R1 armed after reset", idle_irq, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule